// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block is a sixteen-line general-purpose I/O controller reached through a 32-bit register interface. Software sets each pad as an input or a driven output, and sets the value to drive. It reads the pad levels through a two-flop synchronizer. Each of the first thirteen lines can also raise an interrupt. Every line has a 3-bit trigger code that selects one of five conditions: high level, low level, rising edge, falling edge or any change. When the condition is seen on the synchronized pad value, a sticky status bit is set. Software clears that bit by writing a one to it. Each status bit drives its own active-high interrupt wire toward a parent interrupt controller.

The bus is a plain single-cycle port. A write is taken on the clock edge while `bus_en` and `bus_we` are high. Read data is combinational from the word address while `bus_en` is high and `bus_we` is low. The word index is `bus_addr[5:2]`, and bits [1:0] are ignored. The two registers for pad clock output and input filtering only hold their values. They have no effect on the pads.

There is no control state machine. The only sequencing lives in each line's detector. Its two states are the current synchronized level and the level seen one cycle earlier. A transition is a change between those two samples.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The word registers are: index 0 drive value (16 bits), index 1 direction (16 bits), index 2 pad levels (read only), index 3 interrupt status, index 4 trigger codes for lines 0–7, index 5 trigger codes for lines 8–15, index 6 clock-output storage (32 bits), index 7 filter-select storage (32 bits). Each writable register reads back what was written, with bits beyond its width reading 0. Word indices 8 to 15 read as 0.
- R2: After reset, the direction register reads 0xFFFF. Every other register reads 0, `pad_drive` is 0 and `irq_out` is 0.
- R3: A direction bit of 1 makes the line an input (`pad_drive` low). A 0 makes `pad_drive` high for that line, and `pad_out` carries the drive value register.
- R4: The pad-level register returns `pad_in` in bits [15:0] after two clock edges of synchronization, with bits [31:16] zero.
- R5: The trigger code of line n sits at bits [3n+2:3n] of index 4 for n < 8, and at bits [3(n−8)+2:3(n−8)] of index 5 for n ≥ 8.
- R6: Code 0 (level high) and code 1 (level low) set the status bit on every cycle that the condition holds, so a clear has no lasting effect while the condition holds. Once the condition ends, the bit stays set until it is cleared.
- R7: Code 2 (rising), code 3 (falling) and code 4 (any change) set the status bit on that transition of the synchronized level. The bit stays set after the pad returns until software clears it.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a detection occurs on the same edge as the clear, the bit stays set.
- R9: Lines 13 to 15 never set status. Status bits [31:13] always read 0.
- R10: Codes 5, 6 and 7 disable detection for that line.
- R11: `irq_out[i]` is high exactly when status bit i is set.
- R12: A pad change that meets an edge condition appears on `irq_out` at the third rising clock edge after it is applied: two synchronizer flops, then the status flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Value to drive onto each pad |
| pad_drive | output | 16 | 1 = the pad is driven from `pad_out` |
| irq_out | output | 13 | Active-high interrupt level per interrupt-capable line |

## Verification
The bench uses the default parameters: sixteen lines, thirteen of them interrupt-capable, two synchronizer stages and a 6-bit byte address. With these values, both trigger-code registers are used. The split between the low register (line 2 as rising, line 0 as level-low, line 5 as level-high) and the high register (line 9 as falling, line 12 as any-change) is exercised, and so are the three lines with no interrupt. The two-stage synchronizer sets the exact three-edge latency that the timing and same-edge clear cases are sampled against.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int MODE_W          = 3;
    localparam int LINES_PER_STYLE = 8;
    localparam int STYLE_W         = MODE_W * LINES_PER_STYLE;

    // word indices of the register file
    localparam int IDX_DOUT   = 0;
    localparam int IDX_DIR    = 1;
    localparam int IDX_PIN    = 2;
    localparam int IDX_STAT   = 3;
    localparam int IDX_STY_LO = 4;
    localparam int IDX_STY_HI = 5;
    localparam int IDX_CKOUT  = 6;
    localparam int IDX_FILT   = 7;

    typedef enum logic [MODE_W-1:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_ANY    = 3'd4
    } trig_mode_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    output logic              hit
);

    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        unique case (mode)
            TRIG_LVL_HI: hit = lvl;
            TRIG_LVL_LO: hit = ~lvl;
            TRIG_RISE:   hit = rise;
            TRIG_FALL:   hit = fall;
            TRIG_ANY:    hit = rise | fall;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IRQ_LINES = 13,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pin_sync,
    input  logic [IRQ_LINES-1:0] hit,
    output logic [NUM_LINES-1:0] dout_q,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [STYLE_W-1:0]   sty_lo_q,
    output logic [STYLE_W-1:0]   sty_hi_q,
    output logic [IRQ_LINES-1:0] status_q
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]     idx;
    logic                 wr_stb;
    logic [IRQ_LINES-1:0] stat_clr;
    logic [DATA_W-1:0]    ckout_q;
    logic [DATA_W-1:0]    filt_q;
    logic [1:0]           unused_addr_lsb;

    assign idx             = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = bus_addr[1:0];
    assign wr_stb          = bus_en & bus_we;
    assign stat_clr        = (wr_stb && idx == IDX_W'(IDX_STAT)) ?
                             bus_wdata[IRQ_LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q   <= '0;
            dir_q    <= '1;
            sty_lo_q <= '0;
            sty_hi_q <= '0;
            ckout_q  <= '0;
            filt_q   <= '0;
        end else if (wr_stb) begin
            case (idx)
                IDX_W'(IDX_DOUT):   dout_q   <= bus_wdata[NUM_LINES-1:0];
                IDX_W'(IDX_DIR):    dir_q    <= bus_wdata[NUM_LINES-1:0];
                IDX_W'(IDX_STY_LO): sty_lo_q <= bus_wdata[STYLE_W-1:0];
                IDX_W'(IDX_STY_HI): sty_hi_q <= bus_wdata[STYLE_W-1:0];
                IDX_W'(IDX_CKOUT):  ckout_q  <= bus_wdata;
                IDX_W'(IDX_FILT):   filt_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // sticky status: a detection on the clearing edge wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~stat_clr) | hit;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (idx)
                IDX_W'(IDX_DOUT):   bus_rdata = DATA_W'(dout_q);
                IDX_W'(IDX_DIR):    bus_rdata = DATA_W'(dir_q);
                IDX_W'(IDX_PIN):    bus_rdata = DATA_W'(pin_sync);
                IDX_W'(IDX_STAT):   bus_rdata = DATA_W'(status_q);
                IDX_W'(IDX_STY_LO): bus_rdata = DATA_W'(sty_lo_q);
                IDX_W'(IDX_STY_HI): bus_rdata = DATA_W'(sty_hi_q);
                IDX_W'(IDX_CKOUT):  bus_rdata = ckout_q;
                IDX_W'(IDX_FILT):   bus_rdata = filt_q;
                default:            bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_LINES   = 16,
    parameter int IRQ_LINES   = 13,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_drive,
    output logic [IRQ_LINES-1:0] irq_out
);

    localparam int ALL_STYLE_W = 2 * STYLE_W;

    logic [NUM_LINES-1:0]   pin_sync;
    logic [IRQ_LINES-1:0]   hit;
    logic [NUM_LINES-1:0]   dout_q;
    logic [NUM_LINES-1:0]   dir_q;
    logic [STYLE_W-1:0]     sty_lo_q;
    logic [STYLE_W-1:0]     sty_hi_q;
    logic [IRQ_LINES-1:0]   status_q;
    logic [ALL_STYLE_W-1:0] style_all;
    logic                   unused_style_bits;

    gpio_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio_regs #(
        .NUM_LINES (NUM_LINES),
        .IRQ_LINES (IRQ_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .hit       (hit),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .sty_lo_q  (sty_lo_q),
        .sty_hi_q  (sty_hi_q),
        .status_q  (status_q)
    );

    // line n's code sits at 3n in the concatenation, for both halves
    assign style_all         = {sty_hi_q, sty_lo_q};
    assign unused_style_bits = ^style_all[ALL_STYLE_W-1:IRQ_LINES*MODE_W];

    for (genvar i = 0; i < IRQ_LINES; i++) begin : g_det
        gpio_line_detect u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (pin_sync[i]),
            .mode  (style_all[i*MODE_W +: MODE_W]),
            .hit   (hit[i])
        );
    end

    assign pad_out   = dout_q;
    assign pad_drive = ~dir_q;
    assign irq_out   = status_q;

endmodule

// File: rtl/gpio_irq_ctrl_checker.sv
module gpio_irq_ctrl_checker #(
    parameter int NUM_LINES = 16,
    parameter int IRQ_LINES = 13,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_en,
    input logic                 bus_we,
    input logic [ADDR_W-3:0]    word_idx,
    input logic [NUM_LINES-1:0] wr_lo,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] pad_in,
    input logic [NUM_LINES-1:0] pad_drive,
    input logic [IRQ_LINES-1:0] irq_out
);

    logic [1:0] live_cnt;
    logic       rd_stb;
    logic       wr_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    assign rd_stb = bus_en & ~bus_we;
    assign wr_stb = bus_en & bus_we;

    assert_undef_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && word_idx >= (ADDR_W-2)'(8)) |-> bus_rdata == '0);

    assert_dir_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && word_idx == (ADDR_W-2)'(1)) |=> pad_drive == ~$past(wr_lo));

    assert_pin_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt == 2'd3 && rd_stb && word_idx == (ADDR_W-2)'(2))
        |-> bus_rdata == DATA_W'($past(pad_in, 2)));

    assert_no_high_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && word_idx == (ADDR_W-2)'(3))
        |-> bus_rdata[DATA_W-1:IRQ_LINES] == '0);

    assert_irq_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && word_idx == (ADDR_W-2)'(3))
        |-> bus_rdata[IRQ_LINES-1:0] == irq_out);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_checker #(
    .NUM_LINES (NUM_LINES),
    .IRQ_LINES (IRQ_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .word_idx  (bus_addr[ADDR_W-1:2]),
    .wr_lo     (bus_wdata[NUM_LINES-1:0]),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_drive (pad_drive),
    .irq_out   (irq_out)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pads = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_drive;
    logic [12:0] irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pads),
        .pad_out   (pad_out),
        .pad_drive (pad_drive),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'(idx * 4); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'(idx * 4);
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // trigger-code register value: all lines disabled except one line
    function automatic logic [31:0] style_one(input int local_line, input int code);
        logic [31:0] v = 32'h00FF_FFFF;
        v &= ~(32'h7 << (3 * local_line));
        v |= 32'(code) << (3 * local_line);
        return v;
    endfunction

    function automatic logic [31:0] reg_mask(input int idx);
        return (idx < 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] shadow [8];
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2 reset values
        for (int i = 0; i < 8; i++) begin
            if (i == 2) continue;
            rd(i, r);
            chk("R2 reset register", r, (i == 1) ? 32'h0000_FFFF : 32'h0);
        end
        chk("R2 reset pad_drive", 32'(pad_drive), 32'h0);
        chk("R2 reset irq_out", 32'(irq_out), 32'h0);

        // R10 disable all lines, R5 readback of code registers
        wr(4, 32'h00FF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        rd(5, r);
        chk("R5 code register width", r, 32'h00FF_FFFF);

        // R4 two-edge synchronization
        @(negedge clk);
        pads = 16'hA5C3;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 6'd8;
        @(negedge clk);
        chk("R4 pad level after one edge", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R4 pad level after two edges", bus_rdata, 32'h0000_A5C3);
        bus_en = 1'b0;
        idle(3);
        rd(3, r);
        chk("R10 codes 5-7 never set status", r, 32'h0);
        pads = '0;
        idle(3);

        // R1 / R3 storage, drive and undefined space
        wr(0, 32'h1234_5678);
        chk("R3 pad_out follows drive value", 32'(pad_out), 32'h5678);
        wr(1, 32'h0000_00FF);
        chk("R3 direction 0 drives pad", 32'(pad_drive), 32'hFF00);
        rd(0, r);
        chk("R1 drive value readback", r, 32'h5678);
        wr(6, 32'hDEAD_BEEF);
        rd(6, r);
        chk("R1 clock-output storage", r, 32'hDEAD_BEEF);
        wr(7, 32'h0BAD_F00D);
        rd(7, r);
        chk("R1 filter storage", r, 32'h0BAD_F00D);
        rd(8, r);
        chk("R1 undefined index 8", r, 32'h0);
        rd(15, r);
        chk("R1 undefined index 15", r, 32'h0);
        wr(1, 32'h0000_FFFF);
        chk("R3 direction 1 releases pad", 32'(pad_drive), 32'h0);

        // R7 rising on line 2, R12 latency
        wr(4, style_one(2, 2));
        @(negedge clk);
        pads[2] = 1'b1;
        idle(2);
        chk("R12 no irq after two edges", 32'(irq_out[2]), 32'h0);
        idle(1);
        chk("R12 irq at third edge", 32'(irq_out[2]), 32'h1);
        pads[2] = 1'b0;
        idle(3);
        chk("R7 rising status sticky", 32'(irq_out[2]), 32'h1);
        wr(3, 32'h0);
        chk("R8 writing zero keeps status", 32'(irq_out[2]), 32'h1);
        wr(3, 32'h4);
        chk("R8 writing one clears status", 32'(irq_out[2]), 32'h0);

        // R8 detection on the clearing edge wins
        pads[2] = 1'b1;
        idle(3);
        pads[2] = 1'b0;
        idle(3);
        chk("R8 status set before race", 32'(irq_out[2]), 32'h1);
        pads[2] = 1'b1;
        idle(2);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'd12; bus_wdata = 32'h4;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        chk("R8 edge on clear cycle wins", 32'(irq_out[2]), 32'h1);
        pads[2] = 1'b0;
        wr(3, 32'h4);
        chk("R8 later clear", 32'(irq_out[2]), 32'h0);
        wr(4, 32'h00FF_FFFF);

        // R7 falling on line 9 (high register, local 1), R5 placement
        wr(5, style_one(1, 3));
        pads[9] = 1'b1;
        idle(4);
        chk("R7 falling ignores rise", 32'(irq_out), 32'h0);
        pads[9] = 1'b0;
        idle(3);
        chk("R5 R7 falling on line 9", 32'(irq_out), 32'h0200);
        wr(3, 32'h0200);

        // R7 any change on line 12 (local 4)
        wr(5, style_one(4, 4));
        pads[12] = 1'b1;
        idle(3);
        chk("R7 any-change rise", 32'(irq_out), 32'h1000);
        wr(3, 32'h1000);
        chk("R7 any-change cleared", 32'(irq_out), 32'h0);
        pads[12] = 1'b0;
        idle(3);
        chk("R7 any-change fall", 32'(irq_out), 32'h1000);
        wr(3, 32'h1000);

        // R9 line 13 configured rising never interrupts
        wr(5, style_one(5, 2));
        pads[13] = 1'b1;
        idle(3);
        pads[13] = 1'b0;
        idle(3);
        rd(3, r);
        chk("R9 line 13 has no status", r, 32'h0);
        wr(5, 32'h00FF_FFFF);

        // R6 level low on line 0, level high on line 5
        wr(4, style_one(0, 1));
        idle(2);
        chk("R6 level-low sets", 32'(irq_out), 32'h1);
        wr(3, 32'h1);
        chk("R6 level-low reasserts after clear", 32'(irq_out), 32'h1);
        pads[0] = 1'b1;
        idle(3);
        chk("R6 level-low latched after release", 32'(irq_out), 32'h1);
        wr(3, 32'h1);
        chk("R6 level-low cleared", 32'(irq_out), 32'h0);
        wr(4, style_one(5, 0));
        pads[5] = 1'b1;
        idle(3);
        chk("R6 level-high sets", 32'(irq_out), 32'h20);
        rd(3, r);
        chk("R11 status read matches irq", r, 32'h20);
        pads[5] = 1'b0;
        idle(3);
        chk("R6 level-high latched", 32'(irq_out), 32'h20);
        wr(3, 32'h20);
        chk("R6 level-high cleared", 32'(irq_out), 32'h0);
        wr(4, 32'h00FF_FFFF);

        // R1 / R3 random register traffic, fixed seed
        void'($urandom(32'h5EED_0042));
        shadow[0] = 32'h5678; shadow[1] = 32'hFFFF;
        shadow[6] = 32'hDEAD_BEEF; shadow[7] = 32'h0BAD_F00D;
        for (int k = 0; k < 150; k++) begin
            int sel;
            int idx;
            logic [31:0] d;
            sel = int'($urandom_range(0, 3));
            idx = (sel < 2) ? sel : sel + 4;
            d = $urandom();
            wr(idx, d);
            shadow[idx] = d & reg_mask(idx);
            rd(idx, r);
            chk("R1 random readback", r, shadow[idx]);
            chk("R3 random pad_out", 32'(pad_out), shadow[0]);
            chk("R3 random pad_drive", 32'(pad_drive), ~shadow[1] & 32'hFFFF);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule